// File: doc/BRIEF.md
# USB Host Transmit Endpoint Controller

This block keeps the control and status state of one host-side transmit endpoint in a USB controller. Software sees a single 16-bit register. Some of its bits are plain settings, some are status flags set by hardware and cleared by software, some are gated writes, and some are write-only strobes. The protocol engine reports how each transaction ended: ACK, NAK, STALL, no handshake, or sent with no handshake expected. The block answers these events by sequencing the packet-ready flag, the DATA0/DATA1 toggle, the retry and error state, and a NAK-limit halt.

The block counts how many packets sit in a transmit FIFO of up to `SLOTS` entries. It tells the engine whether to send a SETUP or an OUT token and which data toggle to use. It pulses discard and pointer-reset strobes toward the FIFO. It raises a DMA request while a slot is free and pulses an interrupt on packet completion and on error conditions.

Register bit positions:

| Bit | Meaning |
|-----|---------|
| 15–14 | reserved |
| 13 | direction (1 = transmit) |
| 12 | DMA enable |
| 11 | force-toggle |
| 10 | DMA mode |
| 9 | toggle write enable |
| 8 | toggle |
| 7 | NAK timeout |
| 6 | clear-toggle strobe |
| 5 | STALL seen |
| 4 | setup flag |
| 3 | flush strobe |
| 2 | error |
| 1 | FIFO not empty |
| 0 | packet ready |

Top module: `hte_ctrl`

## Requirements
- R1: After reset, `reg_rdata` is 0x0000. `tx_req`, `tok_setup`, `data_tog`, `fifo_drop`, `fifo_ptr_rst`, `dma_req`, `irq` and `ep_dir_tx` are all 0.
- R2: Bits 15, 14, 6 and 3 always read 0. Bits 13, 12, 11 and 10 read back the value last written. `ep_dir_tx` follows bit 13, and `tx_req` is 0 while bit 13 is 0.
- R3: Writes to bit 8 are ignored unless bit 9 already reads 1 when the write occurs. Such a write loads the toggle from bit 8 and clears bit 9. Otherwise, a write loads bit 9 from the written data.
- R4: Writing 1 to bit 6 sets the toggle to 0.
- R5: A write that sets bits 4 and 0 together queues a packet, sets the toggle to 0 and raises `tok_setup`. `tok_setup` falls when the last queued packet completes.
- R6: ACK with a packet queued removes one packet and flips the toggle. A sent event removes one packet and leaves the toggle unchanged. Bit 0 clears when the FIFO empties. Each completion pulses `irq` one cycle later, unless DMA mode 1 is active. Events arriving with an empty FIFO are ignored.
- R7: STALL with a packet queued sets bit 5, empties the FIFO, clears bit 0, pulses `fifo_drop`, `fifo_ptr_rst` and `irq`, and holds `tx_req` low.
- R8: `ep_type` is encoded 0 = control, 1 = isochronous, 2 = bulk, 3 = interrupt. For bulk or interrupt, the third no-handshake event on the same packet sets bit 2 and pulses `irq`. ACK restarts the count and NAK leaves it unchanged. Control and isochronous never set bit 2.
- R9: For bulk, a NAK starts a count of `frame_tick` pulses. When that count reaches `nak_limit`, bit 7 sets, `irq` pulses, and `tx_req` stays low until software clears bit 7. A `nak_limit` of 0 disables this.
- R10: Writing 1 to bit 3 while bit 0 reads 1 removes one packet and pulses `fifo_drop` and `fifo_ptr_rst`. Otherwise the write has no effect.
- R11: The FIFO holds at most `SLOTS` (default 2) packets. A queue write (bit 0 = 1) to a full FIFO is ignored. Bit 1 reads 1 while any packet is queued.
- R12: With bit 11 set, a no-handshake event removes the packet and flips the toggle, as if an ACK had arrived.
- R13: `dma_req` equals bit 12 AND bit 13 AND the FIFO not being full. When bits 12 and 10 are both 1, completions raise no `irq`.
- R14: Bits 5, 7 and 2 clear when written 0. Writing 1 to them does not change them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read value |
| ev_ack | input | 1 | ACK handshake received |
| ev_nak | input | 1 | NAK handshake received |
| ev_stall | input | 1 | STALL handshake received |
| ev_noresp | input | 1 | No handshake returned |
| ev_sent | input | 1 | Packet sent, no handshake expected |
| frame_tick | input | 1 | One-cycle frame pulse |
| nak_limit | input | NAK_W | NAK limit in frames, 0 = off |
| ep_type | input | 2 | Endpoint transfer type |
| tx_req | output | 1 | Packet available to send |
| tok_setup | output | 1 | Use SETUP token instead of OUT |
| data_tog | output | 1 | Current data toggle |
| fifo_drop | output | 1 | Discard one packet strobe |
| fifo_ptr_rst | output | 1 | FIFO pointer reset strobe |
| dma_req | output | 1 | DMA load request |
| irq | output | 1 | Interrupt pulse |
| ep_dir_tx | output | 1 | Endpoint direction is transmit |

## Verification
The bench fills both FIFO slots and then writes a third packet. A design that lost the full check would need three ACKs to drain the FIFO instead of two. It writes the toggle with and without the enable already set. A design that used the current write's enable would load the toggle one write early.

It issues flushes on an empty FIFO and then two flushes on a full one. A design that let the strobe act without queued data, or that emptied everything at once, would read back the wrong occupancy. It counts no-handshake retries with an interleaved NAK and counts NAK frames up to just below and exactly at the limit. Off-by-one counters would set the error or timeout flag a step early or late. It also confirms that DMA mode 1 suppresses only the per-packet interrupt, while STALL still raises one.

// File: rtl/hte_pkg.sv
package hte_pkg;
   localparam int B_DIR    = 13;
   localparam int B_DMAEN  = 12;
   localparam int B_FORCE  = 11;
   localparam int B_DMAMD  = 10;
   localparam int B_TOGWE  = 9;
   localparam int B_TOG    = 8;
   localparam int B_NAKTO  = 7;
   localparam int B_CLRTOG = 6;
   localparam int B_STALL  = 5;
   localparam int B_SETUP  = 4;
   localparam int B_FLUSH  = 3;
   localparam int B_ERR    = 2;
   localparam int B_FNE    = 1;
   localparam int B_RDY    = 0;

   typedef enum logic [1:0] {
      EP_CTRL = 2'd0,
      EP_ISO  = 2'd1,
      EP_BULK = 2'd2,
      EP_INTR = 2'd3
   } ep_kind_e;
endpackage

// File: rtl/hte_toggle.sv
module hte_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   input  logic clr,
   input  logic load,
   input  logic load_val,
   output logic tog
);
   // clear beats load, load beats advance
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    tog <= 1'b0;
      else if (clr)  tog <= 1'b0;
      else if (load) tog <= load_val;
      else if (adv)  tog <= ~tog;
   end

   p_clr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !tog);
   p_adv_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clr && !load) |=> (tog != $past(tog)));
endmodule

// File: rtl/hte_occ.sv
module hte_occ #(
   parameter int SLOTS = 2,
   localparam int CW = $clog2(SLOTS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic          clr_all,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full
);
   generate
      if (SLOTS == 1) begin : g_single
         logic held_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        held_q <= 1'b0;
            else if (clr_all)  held_q <= 1'b0;
            else if (push)     held_q <= 1'b1;
            else if (pop)      held_q <= 1'b0;
         end
         assign count = held_q;
      end else begin : g_multi
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 cnt_q <= '0;
            else if (clr_all)           cnt_q <= '0;
            else if (push && !pop && (cnt_q != CW'(SLOTS)))
                                        cnt_q <= cnt_q + 1'b1;
            else if (pop && !push && (cnt_q != '0))
                                        cnt_q <= cnt_q - 1'b1;
         end
         assign count = cnt_q;
      end
   endgenerate

   assign empty = (count == '0);
   assign full  = (count == CW'(SLOTS));

   p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(SLOTS));
   p_clear_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> (count == '0));
endmodule

// File: rtl/hte_watch.sv
module hte_watch #(
   parameter int ERR_TRIES    = 3,
   parameter int NAK_W        = 16,
   parameter bit NAK_TIMER_EN = 1'b1,
   localparam int TW = $clog2(ERR_TRIES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strike,
   input  logic             tries_rst,
   input  logic             nak,
   input  logic             nak_rst,
   input  logic             nak_en,
   input  logic             frame_tick,
   input  logic [NAK_W-1:0] limit,
   output logic             err_set,
   output logic             nak_set
);
   logic [TW-1:0] tries_q;

   assign err_set = strike && (tries_q == TW'(ERR_TRIES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      tries_q <= '0;
      else if (tries_rst || err_set)   tries_q <= '0;
      else if (strike)                 tries_q <= tries_q + 1'b1;
   end

   generate
      if (NAK_TIMER_EN) begin : g_nak_timer
         logic [NAK_W-1:0] ticks_q;
         logic             run_q;
         logic [NAK_W:0]   next_ticks;
         assign next_ticks = {1'b0, ticks_q} + 1'b1;
         assign nak_set = run_q && frame_tick && nak_en && (limit != '0)
                          && (next_ticks >= {1'b0, limit});
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ticks_q <= '0;
               run_q   <= 1'b0;
            end else if (nak_rst || nak_set) begin
               ticks_q <= '0;
               run_q   <= 1'b0;
            end else begin
               if (nak) run_q <= 1'b1;
               if (run_q && frame_tick && nak_en && (limit != '0))
                  ticks_q <= next_ticks[NAK_W-1:0];
            end
         end
      end else begin : g_no_nak_timer
         logic unused_nak_inputs;
         assign unused_nak_inputs = ^{nak, nak_rst, nak_en, frame_tick, limit};
         assign nak_set = 1'b0;
      end
   endgenerate

   p_tries_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tries_q < TW'(ERR_TRIES));
   p_nak_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (limit == '0) |-> !nak_set);
endmodule

// File: rtl/hte_ctrl.sv
module hte_ctrl
   import hte_pkg::*;
#(
   parameter int SLOTS        = 2,
   parameter int ERR_TRIES    = 3,
   parameter int NAK_W        = 16,
   parameter bit NAK_TIMER_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [15:0]      reg_wdata,
   output logic [15:0]      reg_rdata,
   input  logic             ev_ack,
   input  logic             ev_nak,
   input  logic             ev_stall,
   input  logic             ev_noresp,
   input  logic             ev_sent,
   input  logic             frame_tick,
   input  logic [NAK_W-1:0] nak_limit,
   input  logic [1:0]       ep_type,
   output logic             tx_req,
   output logic             tok_setup,
   output logic             data_tog,
   output logic             fifo_drop,
   output logic             fifo_ptr_rst,
   output logic             dma_req,
   output logic             irq,
   output logic             ep_dir_tx
);
   localparam int CW = $clog2(SLOTS + 1);

   generate
      if (SLOTS < 1) begin : g_bad_slots
         $error("SLOTS must be at least 1");
      end
      if (ERR_TRIES < 1) begin : g_bad_tries
         $error("ERR_TRIES must be at least 1");
      end
      if (NAK_W < 1) begin : g_bad_nakw
         $error("NAK_W must be at least 1");
      end
   endgenerate

   logic dir_q, dmaen_q, force_q, dmamd_q, togwe_q;
   logic nakto_q, stall_q, setup_q, err_q, rdy_q;
   logic drop_q, ptr_q, irq_q;

   logic [CW-1:0] occ_count;
   logic          occ_empty, occ_full;
   logic          err_set, nak_set;

   ep_kind_e kind;
   logic     busy, err_kind, is_bulk;
   logic     ack_ok, force_drop, strike, sent_ok, stall_ev, nak_ok;
   logic     complete, sw_push, sw_flush, pop, last_out;
   logic     tog_clr, tog_load;
   logic     unused_wbits;

   assign kind     = ep_kind_e'(ep_type);
   assign busy     = !occ_empty;
   assign err_kind = (kind == EP_BULK) || (kind == EP_INTR);
   assign is_bulk  = (kind == EP_BULK);

   // engine events only count while a packet is queued
   assign ack_ok     = ev_ack && busy;
   assign sent_ok    = ev_sent && busy;
   assign stall_ev   = ev_stall && busy;
   assign nak_ok     = ev_nak && busy;
   assign force_drop = ev_noresp && busy && force_q;
   assign strike     = ev_noresp && busy && !force_q && err_kind;
   assign complete   = ack_ok || force_drop || sent_ok;

   // software strobes
   assign sw_push  = reg_wr && reg_wdata[B_RDY] && !occ_full;
   assign sw_flush = reg_wr && reg_wdata[B_FLUSH] && rdy_q;
   assign pop      = complete || sw_flush;
   assign last_out = pop && !sw_push && (occ_count == CW'(1));

   assign tog_clr  = reg_wr && (reg_wdata[B_CLRTOG] || (reg_wdata[B_SETUP] && sw_push));
   assign tog_load = reg_wr && togwe_q;

   assign unused_wbits = ^{reg_wdata[15:14], reg_wdata[B_FNE]};

   hte_occ #(.SLOTS(SLOTS)) i_occ (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (sw_push),
      .pop     (pop),
      .clr_all (stall_ev),
      .count   (occ_count),
      .empty   (occ_empty),
      .full    (occ_full)
   );

   hte_toggle i_tog (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (ack_ok || force_drop),
      .clr      (tog_clr),
      .load     (tog_load),
      .load_val (reg_wdata[B_TOG]),
      .tog      (data_tog)
   );

   hte_watch #(
      .ERR_TRIES    (ERR_TRIES),
      .NAK_W        (NAK_W),
      .NAK_TIMER_EN (NAK_TIMER_EN)
   ) i_watch (
      .clk        (clk),
      .rst_n      (rst_n),
      .strike     (strike),
      .tries_rst  (complete || stall_ev || sw_flush),
      .nak        (nak_ok),
      .nak_rst    (ack_ok || stall_ev),
      .nak_en     (is_bulk),
      .frame_tick (frame_tick),
      .limit      (nak_limit),
      .err_set    (err_set),
      .nak_set    (nak_set)
   );

   // settings and gated toggle enable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= 1'b0;
         dmaen_q <= 1'b0;
         force_q <= 1'b0;
         dmamd_q <= 1'b0;
         togwe_q <= 1'b0;
      end else if (reg_wr) begin
         dir_q   <= reg_wdata[B_DIR];
         dmaen_q <= reg_wdata[B_DMAEN];
         force_q <= reg_wdata[B_FORCE];
         dmamd_q <= reg_wdata[B_DMAMD];
         togwe_q <= togwe_q ? 1'b0 : reg_wdata[B_TOGWE];
      end
   end

   // status flags: hardware sets, software clears by writing 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stall_q <= 1'b0;
         err_q   <= 1'b0;
         nakto_q <= 1'b0;
      end else begin
         stall_q <= stall_ev || (stall_q && !(reg_wr && !reg_wdata[B_STALL]));
         err_q   <= err_set  || (err_q   && !(reg_wr && !reg_wdata[B_ERR]));
         nakto_q <= nak_set  || (nakto_q && !(reg_wr && !reg_wdata[B_NAKTO]));
      end
   end

   // packet-ready and token selection
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_q   <= 1'b0;
         setup_q <= 1'b0;
      end else if (stall_ev) begin
         rdy_q   <= 1'b0;
         setup_q <= 1'b0;
      end else if (sw_push) begin
         rdy_q   <= 1'b1;
         if (reg_wdata[B_SETUP]) setup_q <= 1'b1;
      end else if (last_out) begin
         rdy_q   <= 1'b0;
         setup_q <= 1'b0;
      end
   end

   // strobes and interrupt
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drop_q <= 1'b0;
         ptr_q  <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         drop_q <= sw_flush || force_drop || stall_ev;
         ptr_q  <= sw_flush || stall_ev;
         irq_q  <= err_set || nak_set || stall_ev
                   || (complete && !(dmaen_q && dmamd_q));
      end
   end

   assign tx_req       = rdy_q && dir_q && !(stall_q || err_q || nakto_q);
   assign tok_setup    = setup_q;
   assign fifo_drop    = drop_q;
   assign fifo_ptr_rst = ptr_q;
   assign irq          = irq_q;
   assign dma_req      = dmaen_q && dir_q && !occ_full;
   assign ep_dir_tx    = dir_q;

   always_comb begin
      reg_rdata           = '0;
      reg_rdata[B_DIR]    = dir_q;
      reg_rdata[B_DMAEN]  = dmaen_q;
      reg_rdata[B_FORCE]  = force_q;
      reg_rdata[B_DMAMD]  = dmamd_q;
      reg_rdata[B_TOGWE]  = togwe_q;
      reg_rdata[B_TOG]    = data_tog;
      reg_rdata[B_NAKTO]  = nakto_q;
      reg_rdata[B_STALL]  = stall_q;
      reg_rdata[B_SETUP]  = setup_q;
      reg_rdata[B_ERR]    = err_q;
      reg_rdata[B_FNE]    = !occ_empty;
      reg_rdata[B_RDY]    = rdy_q;
   end

   p_togwe_self_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && togwe_q) |=> !togwe_q);
   p_stall_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stall_ev |=> (!rdy_q && stall_q && occ_empty));
   p_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (nakto_q || err_q || stall_q) |-> !tx_req);
   p_flush_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_wdata[B_FLUSH] && !rdy_q && !stall_ev) |=> !fifo_ptr_rst);
   p_dma_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (dmaen_q && dmamd_q && complete && !stall_ev && !err_set && !nak_set)
      |=> !irq);
endmodule

// File: tb/test_hte_ctrl.sv
module test_hte_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 37;
   localparam int OP_WR = 0, OP_ACK = 1, OP_NAK = 2, OP_STALL = 3,
                  OP_NORESP = 4, OP_SENT = 5, OP_TICK = 6;

   // {req[39:36], op[35:32], wdata[31:16], expected rdata[15:0]}
   localparam logic [39:0] VEC [NV] = '{
      {4'd2,  4'd0, 16'hC048, 16'h0000}, // R2 reserved bits, R10 flush on empty
      {4'd2,  4'd0, 16'h2000, 16'h2000}, // R2 direction stored
      {4'd3,  4'd0, 16'h2100, 16'h2000}, // R3 toggle write ignored
      {4'd3,  4'd0, 16'h2200, 16'h2200}, // R3 enable set
      {4'd3,  4'd0, 16'h2100, 16'h2100}, // R3 toggle loaded, enable clears
      {4'd4,  4'd0, 16'h2040, 16'h2000}, // R4 clear-toggle
      {4'd11, 4'd0, 16'h2001, 16'h2003}, // R11 queue one
      {4'd6,  4'd1, 16'h0000, 16'h2100}, // R6 ack flips toggle, empties
      {4'd5,  4'd0, 16'h2011, 16'h2013}, // R5 setup clears toggle
      {4'd6,  4'd1, 16'h0000, 16'h2100}, // R6 ack ends setup packet
      {4'd11, 4'd0, 16'h2101, 16'h2103}, // R11 first slot
      {4'd11, 4'd0, 16'h2101, 16'h2103}, // R11 second slot
      {4'd11, 4'd0, 16'h2101, 16'h2103}, // R11 third ignored
      {4'd11, 4'd1, 16'h0000, 16'h2003}, // R11 one left
      {4'd11, 4'd1, 16'h0000, 16'h2100}, // R11 empty after two
      {4'd6,  4'd1, 16'h0000, 16'h2100}, // R6 ack on empty ignored
      {4'd10, 4'd0, 16'h2101, 16'h2103},
      {4'd10, 4'd0, 16'h2101, 16'h2103},
      {4'd10, 4'd0, 16'h2108, 16'h2103}, // R10 first flush
      {4'd10, 4'd0, 16'h2108, 16'h2100}, // R10 second flush
      {4'd10, 4'd0, 16'h2108, 16'h2100}, // R10 flush empty no effect
      {4'd7,  4'd0, 16'h2101, 16'h2103},
      {4'd7,  4'd3, 16'h0000, 16'h2120}, // R7 stall
      {4'd14, 4'd0, 16'h2120, 16'h2120}, // R14 write 1 keeps
      {4'd14, 4'd0, 16'h2100, 16'h2100}, // R14 write 0 clears
      {4'd12, 4'd0, 16'h2901, 16'h2903},
      {4'd12, 4'd4, 16'h0000, 16'h2800}, // R12 forced drop flips
      {4'd12, 4'd0, 16'h2000, 16'h2000},
      {4'd8,  4'd0, 16'h2001, 16'h2003},
      {4'd8,  4'd4, 16'h0000, 16'h2003}, // R8 strike 1
      {4'd8,  4'd4, 16'h0000, 16'h2003}, // R8 strike 2
      {4'd8,  4'd2, 16'h0000, 16'h2003}, // R8 nak does not count
      {4'd8,  4'd4, 16'h0000, 16'h2007}, // R8 strike 3 sets error
      {4'd14, 4'd0, 16'h2002, 16'h2003}, // R14 clear error
      {4'd6,  4'd1, 16'h0000, 16'h2100},
      {4'd6,  4'd0, 16'h2001, 16'h2103},
      {4'd6,  4'd5, 16'h0000, 16'h2100}  // R6 sent keeps toggle
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        ev_ack = 1'b0, ev_nak = 1'b0, ev_stall = 1'b0;
   logic        ev_noresp = 1'b0, ev_sent = 1'b0, frame_tick = 1'b0;
   logic [15:0] nak_limit = '0;
   logic [1:0]  ep_type = 2'd2;
   logic        tx_req, tok_setup, data_tog, fifo_drop, fifo_ptr_rst;
   logic        dma_req, irq, ep_dir_tx;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   hte_ctrl i_hte_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .ev_ack(ev_ack), .ev_nak(ev_nak),
      .ev_stall(ev_stall), .ev_noresp(ev_noresp), .ev_sent(ev_sent),
      .frame_tick(frame_tick), .nak_limit(nak_limit), .ep_type(ep_type),
      .tx_req(tx_req), .tok_setup(tok_setup), .data_tog(data_tog),
      .fifo_drop(fifo_drop), .fifo_ptr_rst(fifo_ptr_rst),
      .dma_req(dma_req), .irq(irq), .ep_dir_tx(ep_dir_tx)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
      end
   endtask

   task automatic step(input int op, input logic [15:0] d);
      @(negedge clk);
      reg_wr     = (op == OP_WR);
      reg_wdata  = d;
      ev_ack     = (op == OP_ACK);
      ev_nak     = (op == OP_NAK);
      ev_stall   = (op == OP_STALL);
      ev_noresp  = (op == OP_NORESP);
      ev_sent    = (op == OP_SENT);
      frame_tick = (op == OP_TICK);
      @(negedge clk);
      reg_wr = 1'b0; ev_ack = 1'b0; ev_nak = 1'b0; ev_stall = 1'b0;
      ev_noresp = 1'b0; ev_sent = 1'b0; frame_tick = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 rdata", reg_rdata, 16'h0000);
      chk("R1 outputs", {8'h00, tx_req, tok_setup, data_tog, fifo_drop,
                         fifo_ptr_rst, dma_req, irq, ep_dir_tx}, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         step(int'(VEC[i][35:32]), VEC[i][31:16]);
         chk($sformatf("R%0d vector %0d", VEC[i][39:36], i), reg_rdata, VEC[i][15:0]);
      end

      // R5 setup token then R6 interrupt per packet
      step(OP_WR, 16'h2011);
      chk("R5 tok_setup", tok_setup, 1'b1);
      chk("R5 toggle zero", data_tog, 1'b0);
      chk("R2 tx_req with dir", tx_req, 1'b1);
      step(OP_ACK, 16'h0);
      chk("R6 irq on completion", irq, 1'b1);
      chk("R5 tok_setup falls", tok_setup, 1'b0);

      // R13 DMA request and interrupt suppression
      step(OP_WR, 16'h3400);
      chk("R13 dma_req empty", dma_req, 1'b1);
      step(OP_WR, 16'h3401);
      step(OP_WR, 16'h3401);
      chk("R13 dma_req full", dma_req, 1'b0);
      step(OP_ACK, 16'h0);
      chk("R13 no irq in mode 1", irq, 1'b0);
      chk("R13 dma_req room", dma_req, 1'b1);
      step(OP_STALL, 16'h0);
      chk("R7 stall irq", irq, 1'b1);
      chk("R7 drop strobe", fifo_drop, 1'b1);
      chk("R7 pointer strobe", fifo_ptr_rst, 1'b1);
      chk("R7 tx_req low", tx_req, 1'b0);
      step(OP_WR, 16'h2000);
      chk("R14 stall cleared", reg_rdata & 16'hFEFF, 16'h2000);

      // R8 control type never errors
      ep_type = 2'd0;
      step(OP_WR, 16'h2001);
      repeat (3) step(OP_NORESP, 16'h0);
      chk("R8 control no error", reg_rdata & 16'h0004, 16'h0000);
      step(OP_ACK, 16'h0);
      ep_type = 2'd3;
      step(OP_WR, 16'h2001);
      repeat (3) step(OP_NORESP, 16'h0);
      chk("R8 interrupt error irq", irq, 1'b1);
      chk("R8 interrupt error bit", reg_rdata & 16'h0004, 16'h0004);
      step(OP_WR, 16'h2000);
      step(OP_ACK, 16'h0);
      ep_type = 2'd2;

      // R9 NAK limit
      nak_limit = 16'd3;
      step(OP_WR, 16'h2001);
      step(OP_NAK, 16'h0);
      step(OP_TICK, 16'h0);
      step(OP_TICK, 16'h0);
      chk("R9 below limit", reg_rdata & 16'h0080, 16'h0000);
      chk("R9 still requesting", tx_req, 1'b1);
      step(OP_TICK, 16'h0);
      chk("R9 timeout bit", reg_rdata & 16'h0080, 16'h0080);
      chk("R9 timeout irq", irq, 1'b1);
      chk("R9 halted", tx_req, 1'b0);
      step(OP_WR, 16'h2000);
      chk("R9 cleared resumes", tx_req, 1'b1);
      nak_limit = 16'd0;
      step(OP_NAK, 16'h0);
      repeat (5) step(OP_TICK, 16'h0);
      chk("R9 limit zero off", reg_rdata & 16'h0080, 16'h0000);
      step(OP_ACK, 16'h0);

      // R10 flush strobes
      step(OP_WR, 16'h2001);
      step(OP_WR, 16'h2008);
      chk("R10 drop strobe", fifo_drop, 1'b1);
      chk("R10 pointer strobe", fifo_ptr_rst, 1'b1);
      chk("R10 ready cleared", reg_rdata & 16'h0003, 16'h0000);
      step(OP_WR, 16'h2008);
      chk("R10 no strobe when empty", fifo_ptr_rst, 1'b0);

      // R2 direction output
      step(OP_WR, 16'h0001);
      chk("R2 dir low", ep_dir_tx, 1'b0);
      chk("R2 no tx_req rx dir", tx_req, 1'b0);
      step(OP_WR, 16'h2000);
      chk("R2 dir high", ep_dir_tx, 1'b1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule